// File: doc/BRIEF.md
# Feedback triple-redundant counter

This block is a free-running up-counter kept in three identical copies. A bitwise two-of-three majority voter combines the copies, and the voted value is the only count the rest of the chip sees. In the default voted-feedback mode, every copy builds its next state from the voted value rather than from its own register. A copy that an upset has corrupted therefore agrees with the other two again after one clock, with no reset and no pause in counting.

A parameter selects plain redundancy instead. In that mode each copy increments only its own register, so a copy that diverges stays wrong until the next reset. The two modes can be compared side by side.

An upset-injection port lets a test overwrite any subset of the copies with a chosen value during one cycle. A per-copy flag shows which copies currently disagree with the voted count.

Top module: `fb_tmr_counter`

## Requirements
- R1: Each bit of `count` is the majority of that bit across the three copies, (a&b)|(a&c)|(b&c), evaluated independently per bit.
- R2: In voted-feedback mode, a copy overwritten by a single injection equals the voted count again after the next clock edge, and its `mismatch` bit clears at that edge.
- R3: In plain mode, a copy that differs from the other two keeps differing, and its `mismatch` bit stays set, until synchronous reset.
- R4: When all copies agree and at most one copy is injected in a cycle, `count` after the edge equals the previous `count` plus `en`, in either mode.
- R5: An injection that writes the same value into two copies in one cycle defeats the vote: `count` becomes that value.
- R6: While `rst_n` is low at a rising edge, all copies load zero, so `count` is 0 and `mismatch` is 3'b000 afterwards.
- R7: For each copy whose `inj_mask` bit (bit 0 = copy 0, bit 2 = copy 2) is set at an edge, that copy loads `inj_val` in place of its normal update. Bit i of `mismatch` is high exactly when copy i differs from `count`.
- R8: With `en` low and no injection, all copies hold their value and `count` is unchanged.
- R9: The count wraps from 2^WIDTH-1 to 0 on the next enabled edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Count enable, applied to all copies |
| inj_mask | input | 3 | One bit per copy; a set bit overwrites that copy this cycle |
| inj_val | input | WIDTH | Value written into the selected copies |
| count | output | WIDTH | Majority-voted count |
| mismatch | output | 3 | Per-copy flag: copy differs from `count` |

## Verification
The single-upset property (R4) only claims anything in cycles where the copies start out in agreement and at most one `inj_mask` bit is set. The stimulus sets two mask bits only in the dedicated double-upset scenario, and in plain mode it applies a second upset only after the copies have already diverged, so that property is never brought into a case it does not cover. The plain-mode persistence property only covers the case where no injection occurs and at most one copy disagrees. The bench keeps plain-mode divergence to a single copy, except in the bitwise-vote scenario, which it ends with a reset.

// File: rtl/tmr_pkg.sv
// Shared definitions for the triple-redundant counter.
// Assumes exactly three copies; the voter and flag logic rely on it.
package tmr_pkg;
    localparam int unsigned COPIES = 3;

    // Source of each copy's next state.
    typedef enum logic {
        FB_PLAIN = 1'b0,  // copy advances from its own register
        FB_VOTED = 1'b1   // copy advances from the voted value
    } fb_mode_e;
endpackage

// File: rtl/tmr_vote3.sv
// Bitwise two-of-three majority voter.
// Assumes the three inputs are the same width; purely combinational.
module tmr_vote3 #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic [WIDTH-1:0] c,
    output logic [WIDTH-1:0] y
);
    // Majority taken independently for every bit position.
    always_comb begin
        y = (a & b) | (a & c) | (b & c);
    end
endmodule

// File: rtl/tmr_count_lane.sv
// One copy of the counter register.
// The next state comes from the voted value or from this copy's own
// register, depending on MODE. An upset write replaces the normal update
// for one cycle. Assumes the reset is synchronous and active low.
module tmr_count_lane #(
    parameter int unsigned        WIDTH = 8,
    parameter tmr_pkg::fb_mode_e  MODE  = tmr_pkg::FB_VOTED
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [WIDTH-1:0] voted,
    input  logic             inj_hit,
    input  logic [WIDTH-1:0] inj_val,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] src;
    logic [WIDTH-1:0] nxt;

    // Pick the state the increment starts from.
    generate
        if (MODE == tmr_pkg::FB_VOTED) begin : g_src_voted
            assign src = voted;
        end else begin : g_src_own
            assign src = q;
        end
    endgenerate

    // Increment only when enabled; otherwise reload the source.
    always_comb begin
        nxt = en ? (src + {{(WIDTH-1){1'b0}}, 1'b1}) : src;
    end

    // Copy register: reset, injected upset, or normal update.
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= '0;
        else if (inj_hit) q <= inj_val;
        else              q <= nxt;
    end

    AST_INJ_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        inj_hit |=> (q == $past(inj_val)));  // R7
endmodule

// File: rtl/tmr_disagree.sv
// Per-copy disagreement flags: bit i is set while copy i differs
// from the voted value. Combinational; assumes packed copies.
module tmr_disagree #(
    parameter int unsigned WIDTH  = 8,
    parameter int unsigned COPIES = 3
) (
    input  logic [COPIES-1:0][WIDTH-1:0] copies,
    input  logic [WIDTH-1:0]             voted,
    output logic [COPIES-1:0]            flags
);
    genvar i;
    generate
        for (i = 0; i < COPIES; i++) begin : g_cmp
            // Compare one copy against the vote.
            assign flags[i] = (copies[i] != voted);
        end
    endgenerate
endmodule

// File: rtl/fb_tmr_counter.sv
// Triple-redundant up-counter with a majority-voted output.
// MODE selects voted-feedback resynchronisation or plain per-copy
// counting. inj_mask/inj_val overwrite copies to model upsets.
// Assumes a single clock shared by all copies and a synchronous
// active-low reset.
module fb_tmr_counter #(
    parameter int unsigned       WIDTH = 8,
    parameter tmr_pkg::fb_mode_e MODE  = tmr_pkg::FB_VOTED
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [2:0]       inj_mask,
    input  logic [WIDTH-1:0] inj_val,
    output logic [WIDTH-1:0] count,
    output logic [2:0]       mismatch
);
    localparam int unsigned NC = tmr_pkg::COPIES;

    logic [NC-1:0][WIDTH-1:0] copy_q;
    logic [WIDTH-1:0]         voted;
    logic [WIDTH-1:0]         step_l;

    genvar i;
    generate
        for (i = 0; i < NC; i++) begin : g_lane
            // One redundant copy of the counter state.
            tmr_count_lane #(.WIDTH(WIDTH), .MODE(MODE)) u_lane (
                .clk     (clk),
                .rst_n   (rst_n),
                .en      (en),
                .voted   (voted),
                .inj_hit (inj_mask[i]),
                .inj_val (inj_val),
                .q       (copy_q[i])
            );
        end
    endgenerate

    // Majority of the three copies.
    tmr_vote3 #(.WIDTH(WIDTH)) u_vote (
        .a (copy_q[0]),
        .b (copy_q[1]),
        .c (copy_q[2]),
        .y (voted)
    );

    // Flag every copy that disagrees with the vote.
    tmr_disagree #(.WIDTH(WIDTH), .COPIES(NC)) u_flags (
        .copies (copy_q),
        .voted  (voted),
        .flags  (mismatch)
    );

    assign count  = voted;
    assign step_l = {{(WIDTH-1){1'b0}}, en};

    AST_RESET_ZERO: assert property (@(posedge clk)
        !rst_n |=> (count == '0 && mismatch == 3'b000));  // R6

    AST_SINGLE_UPSET_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (mismatch == 3'b000 && $countones(inj_mask) <= 1)
        |=> (count == $past(count) + $past(step_l)));  // R4

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && inj_mask == 3'b000 && mismatch == 3'b000) |=> $stable(count));  // R8

    generate
        if (MODE == tmr_pkg::FB_VOTED) begin : g_chk_fb
            AST_FB_REALIGN: assert property (@(posedge clk) disable iff (!rst_n)
                (inj_mask == 3'b000) |=> (mismatch == 3'b000));  // R2
        end else begin : g_chk_plain
            AST_PLAIN_PERSIST: assert property (@(posedge clk) disable iff (!rst_n)
                (inj_mask == 3'b000 && $countones(mismatch) <= 1)
                |=> (mismatch == $past(mismatch)));  // R3
        end
    endgenerate
endmodule

// File: tb/tb_fb_tmr_counter.sv
module tb_fb_tmr_counter;
    localparam int unsigned W = 8;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         en;
    logic [2:0]   inj_mask;
    logic [W-1:0] inj_val;
    logic [W-1:0] count, count_p;
    logic [2:0]   mismatch, mismatch_p;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    fb_tmr_counter #(.WIDTH(W), .MODE(tmr_pkg::FB_VOTED)) dut (
        .clk(clk), .rst_n(rst_n), .en(en), .inj_mask(inj_mask),
        .inj_val(inj_val), .count(count), .mismatch(mismatch)
    );

    fb_tmr_counter #(.WIDTH(W), .MODE(tmr_pkg::FB_PLAIN)) dut_plain (
        .clk(clk), .rst_n(rst_n), .en(en), .inj_mask(inj_mask),
        .inj_val(inj_val), .count(count_p), .mismatch(mismatch_p)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Drive inputs at a falling edge, then wait one full cycle.
    task automatic tick(input logic e, input logic [2:0] m, input logic [W-1:0] v);
        en = e; inj_mask = m; inj_val = v;
        @(negedge clk);
        en = 1'b0; inj_mask = 3'b000; inj_val = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(1'b1, 3'b000, '0);
        tick(1'b1, 3'b000, '0);
        rst_n = 1'b1;
    endtask

    task automatic run(input int n);
        for (int k = 0; k < n; k++) tick(1'b1, 3'b000, '0);
    endtask

    task automatic t_reset();
        run(3);
        do_reset();
        chk("R6 count", count, 0);
        chk("R6 mismatch", mismatch, 0);
        chk("R6 plain count", count_p, 0);
        chk("R6 plain mismatch", mismatch_p, 0);
    endtask

    task automatic t_enable();
        run(5);
        chk("R8 counted", count, 5);
        chk("R8 plain counted", count_p, 5);
        for (int k = 0; k < 3; k++) tick(1'b0, 3'b000, '0);
        chk("R8 hold", count, 5);
        chk("R8 plain hold", count_p, 5);
    endtask

    task automatic t_single_upset();
        // count is 5 here
        tick(1'b1, 3'b010, 8'hA5);
        chk("R4 masked", count, 6);
        chk("R4 plain masked", count_p, 6);
        chk("R7 flag", mismatch, 3'b010);
        chk("R7 plain flag", mismatch_p, 3'b010);
        tick(1'b1, 3'b000, '0);
        chk("R2 realigned flag", mismatch, 3'b000);
        chk("R2 count", count, 7);
        chk("R3 plain still diverged", mismatch_p, 3'b010);
        run(3);
        chk("R3 plain persists", mismatch_p, 3'b010);
        chk("R3 plain count", count_p, 10);
        chk("R2 count later", count, 10);
        do_reset();
        chk("R3 cleared by reset", mismatch_p, 3'b000);
    endtask

    task automatic t_double_upset();
        run(3);
        tick(1'b1, 3'b101, 8'h40);
        chk("R5 vote defeated", count, 8'h40);
        chk("R5 plain vote defeated", count_p, 8'h40);
        chk("R7 odd copy flagged", mismatch, 3'b010);
        tick(1'b1, 3'b000, '0);
        chk("R5 wrong value carried", count, 8'h41);
        do_reset();
    endtask

    task automatic t_bitwise_vote();
        run(8'h3C);
        tick(1'b0, 3'b001, 8'hF0);
        chk("R1 one copy off", count_p, 8'h3C);
        chk("R7 plain flag copy0", mismatch_p, 3'b001);
        tick(1'b0, 3'b010, 8'hCC);
        // copies F0, CC, 3C -> majority FC
        chk("R1 bitwise majority", count_p, 8'hFC);
        chk("R1 all differ", mismatch_p, 3'b111);
        chk("R2 voted mode held", count, 8'h3C);
        chk("R7 voted flag copy1", mismatch, 3'b010);
        do_reset();
    endtask

    task automatic t_wrap();
        run(255);
        chk("R9 top value", count, 8'hFF);
        tick(1'b1, 3'b000, '0);
        chk("R9 wrap", count, 0);
        chk("R9 plain wrap", count_p, 0);
    endtask

    initial begin
        rst_n = 1'b0; en = 1'b0; inj_mask = 3'b000; inj_val = '0;
        @(negedge clk);
        t_reset();
        t_enable();
        t_single_upset();
        t_double_upset();
        t_bitwise_vote();
        t_wrap();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule